// File: doc/BRIEF.md
# Multi-Chip Memory Bank with Row Decoding

This block assembles a processor-visible word memory of 2^ADDR_W words, each DATA_W bits wide, from a grid of identical storage chips. Every chip holds 2^CHIP_AW entries of LANE_W bits. The upper ADDR_W − CHIP_AW address bits pick one row of chips. Each row holds DATA_W / LANE_W chips placed side by side, and each chip in a row serves one lane of the data word.

The processor side has the following signals:
- an address
- a write word
- a read word
- a read/write-bar line, where 1 means read and 0 means write
- an address strobe

The strobe gates the row decoder. The read/write-bar line becomes the output enable of every chip, and its inverse becomes the write enable of every chip. The chips share no tri-state bus: the lane outputs of the selected row are merged into the read word. The one-hot row-select vector is also brought out, so that the decode can be observed.

Top module: `mem_bank`

## Requirements
- R1: While the strobe is 1, `row_sel_o` is one-hot. Bit r is set exactly when `addr_i[ADDR_W-1:CHIP_AW]` equals r. Row r therefore covers word addresses r·2^CHIP_AW to (r+1)·2^CHIP_AW − 1. With the default parameters, address 0x4A selects row 1 only (`row_sel_o` = 4'b0010), at chip offset 0x0A.
- R2: While the strobe is 0, `row_sel_o` is all zero, `rdata_o` is zero, and no location changes.
- R3: On a rising clock edge with the strobe at 1 and read/write-bar at 0, the word `wdata_i` is stored at chip offset `addr_i[CHIP_AW-1:0]` of the addressed row. Lane k, meaning bits [LANE_W·k+LANE_W−1 : LANE_W·k], goes to that row's chip in column k.
- R4: While the strobe is 1 and read/write-bar is 1, `rdata_o` combinationally shows the word last stored at `addr_i`, assembled lane by lane from the addressed row. During a write cycle, `rdata_o` is zero.
- R5: A write changes only the addressed row. Words at the same chip offset in the other rows keep their contents.
- R6: A cycle with read/write-bar at 1 stores nothing, whatever `wdata_i` carries.
- R7: No chip ever has its output enable and its write enable high together while it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes take effect on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; it qualifies the checks and has no effect on storage |
| addr_i | input | ADDR_W | Processor word address |
| wdata_i | input | DATA_W | Word to write |
| rw_i | input | 1 | 1 = read, 0 = write |
| as_i | input | 1 | Address strobe; 1 = valid access |
| rdata_o | output | DATA_W | Read word from the addressed row, zero otherwise |
| row_sel_o | output | 2^(ADDR_W−CHIP_AW) | Chip select of each row |

## Verification
The assertions assume that `rw_i` and `as_i` are always 0 or 1 and never unknown. They also assume that every location is written before it is read, since storage has no reset value. The bench keeps within these limits. It first writes the whole address space, then exercises decode, isolation between rows and ignored write data. After that it runs a mixed random phase, in which reads can only hit locations that have already been filled. In every cycle, a behavioural word array predicts `rdata_o` and `row_sel_o` from the inputs alone.

// File: rtl/mem_bank_pkg.sv
package mem_bank_pkg;
  typedef struct packed {
    logic cs;
    logic oe;
    logic we;
  } chip_ctrl_t;
endpackage

// File: rtl/bank_row_decoder.sv
module bank_row_decoder #(
  parameter int ROW_BITS = 2,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int IDX_W   = (ROW_BITS > 0) ? ROW_BITS : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] row_i,
  output logic [ROWS-1:0]  sel_o
);
  generate
    if (ROW_BITS == 0) begin : g_single
      logic unused_row;
      assign unused_row = ^row_i;
      assign sel_o = en_i;
    end else begin : g_decode
      always_comb begin
        sel_o = '0;
        for (int r = 0; r < ROWS; r++)
          if (en_i && (row_i == IDX_W'(r))) sel_o[r] = 1'b1;
      end
    end
  endgenerate

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> $countones(sel_o) == 1) else $error("row select not one-hot"); // R1
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> sel_o == '0) else $error("row select without strobe"); // R2
endmodule

// File: rtl/bank_chip.sv
module bank_chip
  import mem_bank_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  chip_ctrl_t    ctrl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ctrl_i.cs && ctrl_i.we && !ctrl_i.oe) mem_q[addr_i] <= wdata_i;
  end

  // gated output stands in for a released bus
  assign rdata_o = (ctrl_i.cs && ctrl_i.oe && !ctrl_i.we) ? mem_q[addr_i] : '0;

  AST_NO_OE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.cs |-> !(ctrl_i.oe && ctrl_i.we)) else $error("oe and we both high"); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.cs && ctrl_i.we) |=> mem_q[$past(addr_i)] == $past(wdata_i))
    else $error("write lost"); // R3
endmodule

// File: rtl/mem_bank.sv
module mem_bank
  import mem_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int CHIP_AW = 6,
  parameter int LANE_W  = 8,
  localparam int ROW_BITS = ADDR_W - CHIP_AW,
  localparam int ROWS     = 1 << ROW_BITS,
  localparam int LANES    = DATA_W / LANE_W,
  localparam int IDX_W    = (ROW_BITS > 0) ? ROW_BITS : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rw_i,
  input  logic              as_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ROWS-1:0]   row_sel_o
);
  generate
    if (ADDR_W < CHIP_AW || (DATA_W % LANE_W) != 0) begin : g_bad_cfg
      $error("mem_bank: need ADDR_W >= CHIP_AW and DATA_W a multiple of LANE_W");
    end
  endgenerate

  logic [IDX_W-1:0]   row_idx;
  logic [CHIP_AW-1:0] chip_addr;
  logic [LANE_W-1:0]  lane_rd [ROWS][LANES];

  assign chip_addr = addr_i[CHIP_AW-1:0];

  generate
    if (ROW_BITS > 0) begin : g_row_idx
      assign row_idx = addr_i[ADDR_W-1:CHIP_AW];
    end else begin : g_no_row_idx
      assign row_idx = '0;
    end
  endgenerate

  bank_row_decoder #(.ROW_BITS(ROW_BITS)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (as_i),
    .row_i (row_idx),
    .sel_o (row_sel_o)
  );

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      chip_ctrl_t row_ctrl;
      assign row_ctrl.cs = row_sel_o[r];
      assign row_ctrl.oe = rw_i;
      assign row_ctrl.we = ~rw_i;
      for (genvar k = 0; k < LANES; k++) begin : g_lane
        bank_chip #(.AW(CHIP_AW), .DW(LANE_W)) u_chip (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .ctrl_i (row_ctrl),
          .addr_i (chip_addr),
          .wdata_i(wdata_i[k*LANE_W +: LANE_W]),
          .rdata_o(lane_rd[r][k])
        );
      end
    end
  endgenerate

  // unselected chips drive zero, so OR across rows is the row mux
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < LANES; k++)
        rdata_o[k*LANE_W +: LANE_W] = rdata_o[k*LANE_W +: LANE_W] | lane_rd[r][k];
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |-> rdata_o == '0) else $error("read data without strobe"); // R2
  AST_RD_ON_WRITE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_i && !rw_i) |-> rdata_o == '0) else $error("read data during write"); // R4
endmodule

// File: tb/tb_mem_bank.sv
module tb_mem_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CAW = 6;
  localparam int NROWS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rw = 1'b1;
  logic          as_s = 1'b0;
  logic [DW-1:0] rdata;
  logic [NROWS-1:0] row_sel;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] ref_mem [2**AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rw_i(rw), .as_i(as_s), .rdata_o(rdata), .row_sel_o(row_sel)
  );

  task automatic check_out(input string tag);
    logic [NROWS-1:0] exp_sel;
    logic [DW-1:0] exp_rd;
    exp_sel = as_s ? NROWS'(1 << (addr / (2**CAW))) : '0;
    exp_rd  = (as_s && rw) ? ref_mem[addr] : '0;
    checks++;
    if (row_sel !== exp_sel) begin
      failures++;
      $display("FAIL %s R1/R2 row_sel addr=%h actual=%b expected=%b", tag, addr, row_sel, exp_sel);
    end
    checks++;
    if (rdata !== exp_rd) begin
      failures++;
      $display("FAIL %s R4/R2 rdata addr=%h actual=%h expected=%h", tag, addr, rdata, exp_rd);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    as_s = s; rw = r; addr = a; wdata = d;
    #1 check_out(tag);
    @(posedge clk);
    if (s && !r) ref_mem[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_out("reset R2");
    rst_n = 1'b1;
    // R3: fill every word
    for (int i = 0; i < 2**AW; i++) cyc(1'b1, 1'b0, AW'(i), DW'(i * 16'h0101 ^ 16'h5A3C), "fill R3");
    // R4: read back all
    for (int i = 0; i < 2**AW; i++) cyc(1'b1, 1'b1, AW'(i), '0, "readback R4");
    // R1: 0x4A -> row 1 only
    cyc(1'b1, 1'b1, 8'h4A, '0, "decode R1");
    checks++;
    if (row_sel !== 4'b0010) begin
      failures++;
      $display("FAIL R1 addr 4A actual=%b expected=%b", row_sel, 4'b0010);
    end
    // R5: write row 0 offset 5, other rows at offset 5 untouched
    cyc(1'b1, 1'b0, 8'h05, 16'hBEEF, "iso write R5");
    for (int r = 0; r < NROWS; r++) cyc(1'b1, 1'b1, AW'(r * 64 + 5), '0, "iso read R5");
    // R6: read cycles carry junk write data
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, AW'(i * 33), 16'hFFFF, "no-store R6");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, AW'(i * 33), '0, "no-store R6");
    // R2: idle with write level and data, then confirm untouched
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, AW'(i * 17), 16'h0000, "idle R2");
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, AW'(i * 17), '0, "idle R2");
    // lane split R3: distinct bytes in both lanes
    cyc(1'b1, 1'b0, 8'hC3, 16'h12F0, "lane R3");
    cyc(1'b1, 1'b1, 8'hC3, '0, "lane R3");
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
          AW'($urandom), DW'($urandom), "random R1/R3/R4/R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule